// File: doc/BRIEF.md
# Vectored Interrupt Controller with Rotating Priority

This block collects up to 64 interrupt request lines and presents them to a processor as two outputs: a normal interrupt request and a fast interrupt request. Each source owns one configuration byte. That byte holds an enable bit, a trigger selection (high level, rising edge, falling edge or either edge) and a three-bit destination code. Destination 0 feeds the normal output and destination 1 feeds the fast output. Codes 2 to 7 are accepted and stored, but they feed neither output.

Detected events are held in two 32-bit pending words, and software clears them by writing ones. For each output, an arbiter picks one winner among the pending, enabled sources routed to that output. It reports the winner's number through a priority register, which software reads at handler entry. Each priority register has its own mode bit that selects fixed priority or rotating priority. When nothing qualifies, the register reports the top source number. Software separates that idle value from a real request on the top source by looking at the top bit of the upper pending word.

All accesses go through a simple single-cycle register bus with byte strobes. Reads are combinational and have no side effects. Inputs are assumed synchronous to the clock.

Top module: `vic_rot`

## Requirements
- R1: After reset, every configuration byte reads 0, so every source is disabled and routed to destination 0. Both priority registers read 0x3F with the mode bit clear, and both outputs are low.
- R2: The configuration byte of source n sits at byte address 0x40+n, with four sources per 32-bit word and byte lane n mod 4. Bit 3 is the enable, bits 6:5 are the trigger and bits 2:0 are the destination. Only those bits read back; bits 7 and 4 read 0. A lane with its strobe low is left unchanged.
- R3: With trigger 00 (high level), the pending bit equals the input as sampled at the previous clock edge. Writing 1 to it has no lasting effect while the input stays high.
- R4: With trigger 01 (rising edge), a low-to-high input transition sets the pending bit. The bit stays set after the input falls, until a write of 1 clears it.
- R5: With trigger 10, a falling edge sets the pending bit. With trigger 11, either edge sets it.
- R6: Pending bits are read at 0x80 (sources 0 to 31, bit n) and 0x84 (sources 32 to 63, bit n-32). Writing 1 clears a bit. Writing 0 leaves it unchanged.
- R7: irq_o is high when any pending, enabled source has destination 0. fiq_o does the same for destination 1. A source with destination 2 to 7 drives neither output.
- R8: Reading 0x20 (normal output) or 0x24 (fast output) returns the winner in bits 5:0 and the mode bit in bit 6. Bit 6 is writable. With no candidate, bits 5:0 read 63. A real request on source 63 is visible as bit 31 of 0x84.
- R9: In fixed mode (bit 6 = 0), the winner is the lowest-numbered candidate.
- R10: In rotating mode, the search starts one position above the last source that was that output's winner when a status write cleared it, and wraps past 63 to 0. After reset, the search starts at 0.
- R11: A disabled source still records pending status, but it does not raise an output or take part in arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wstrb | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_in | input | 64 | Interrupt request lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that src_in is synchronous to clk. They also assume the request lines are low while reset is applied, so that no stray edge is seen just after release. Level tracking and edge holding are checked only from the second clock edge after reset, because their past values must be meaningful. The bench keeps within these limits: it changes inputs and bus signals only at the falling clock edge, holds all request lines low across every reset, and issues each register write as a single-cycle strobe.

// File: rtl/vic_rot_pkg.sv
package vic_rot_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_FALL  = 2'b10,
    TRIG_ANY   = 2'b11
  } trig_e;

  typedef struct packed {
    trig_e      trig;
    logic       en;
    logic [2:0] dest;
  } src_cfg_t;

  localparam logic [2:0] DEST_IRQ = 3'd0;
  localparam logic [2:0] DEST_FIQ = 3'd1;
  localparam int         NDEST    = 2;
  localparam int         ROT_BIT  = 6;

  // 32-bit word indices (byte address bits 7:2)
  localparam logic [5:0] WIDX_PRIO_IRQ  = 6'h08;
  localparam logic [5:0] WIDX_PRIO_FIQ  = 6'h09;
  localparam logic [5:0] WIDX_CFG_BASE  = 6'h10;
  localparam logic [5:0] WIDX_STAT_BASE = 6'h20;

  function automatic logic [7:0] cfg_to_byte(src_cfg_t c);
    return {1'b0, c.trig, 1'b0, c.en, c.dest};
  endfunction

  function automatic src_cfg_t byte_to_cfg(logic [7:0] b);
    src_cfg_t c;
    c.trig = trig_e'(b[6:5]);
    c.en   = b[3];
    c.dest = b[2:0];
    return c;
  endfunction

endpackage

// File: rtl/vic_rot_cfg.sv
module vic_rot_cfg
  import vic_rot_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [5:0]                widx,
  input  logic [3:0]                wstrb,
  input  logic [31:0]               wdata,
  output src_cfg_t [NSRC-1:0]       cfg,
  output logic [NDEST-1:0]          rot_mode,
  output logic [NSRC-1:0]           clr_mask
);

  src_cfg_t [NSRC-1:0] cfg_q, cfg_d;
  logic     [NSRC-1:0] cfg_we;
  logic [NDEST-1:0]    rot_q, rot_d, rot_we;

  // per-source write enables and status clear mask
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam logic [5:0] CFG_W  = WIDX_CFG_BASE  + 6'(i / 4);
      localparam logic [5:0] STAT_W = WIDX_STAT_BASE + 6'(i / 32);
      localparam int         LANE   = i % 4;
      localparam int         SBIT   = i % 32;
      assign cfg_we[i]   = wr_en && (widx == CFG_W) && wstrb[LANE];
      assign cfg_d[i]    = byte_to_cfg(wdata[8*LANE +: 8]);
      assign clr_mask[i] = wr_en && (widx == STAT_W) && wstrb[SBIT/8] && wdata[SBIT];
    end
  endgenerate

  always_comb begin
    rot_we[0] = wr_en && (widx == WIDX_PRIO_IRQ) && wstrb[0];
    rot_we[1] = wr_en && (widx == WIDX_PRIO_FIQ) && wstrb[0];
    rot_d     = {wdata[ROT_BIT], wdata[ROT_BIT]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rot_q <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (cfg_we[i]) cfg_q[i] <= cfg_d[i];
      end
      for (int d = 0; d < NDEST; d++) begin
        if (rot_we[d]) rot_q[d] <= rot_d[d];
      end
    end
  end

  assign cfg      = cfg_q;
  assign rot_mode = rot_q;

endmodule

// File: rtl/vic_rot_pend.sv
module vic_rot_pend
  import vic_rot_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     src_in,
  input  src_cfg_t [NSRC-1:0] cfg,
  input  logic [NSRC-1:0]     clr_mask,
  output logic [NSRC-1:0]     pend
);

  logic [NSRC-1:0] src_q, pend_q, pend_d, rise, fall;

  assign rise = src_in & ~src_q;
  assign fall = ~src_in & src_q;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      unique case (cfg[i].trig)
        TRIG_LEVEL: pend_d[i] = src_in[i];
        TRIG_RISE:  pend_d[i] = (pend_q[i] & ~clr_mask[i]) | rise[i];
        TRIG_FALL:  pend_d[i] = (pend_q[i] & ~clr_mask[i]) | fall[i];
        TRIG_ANY:   pend_d[i] = (pend_q[i] & ~clr_mask[i]) | rise[i] | fall[i];
        default:    pend_d[i] = pend_q[i];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_in;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/vic_rot_arb.sv
module vic_rot_arb #(
  parameter int NSRC = 64,
  parameter int IDW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] cand,
  input  logic            rotate,
  input  logic [NSRC-1:0] clr_mask,
  output logic [IDW-1:0]  winner,
  output logic            active
);

  localparam logic [IDW-1:0] TOP_ID = IDW'(NSRC - 1);
  localparam logic [IDW:0]   NSRC_W = (IDW + 1)'(NSRC);

  logic [IDW-1:0]    last_q, last_d, shift, pick;
  logic [2*NSRC-1:0] dbl;
  logic [NSRC-1:0]   rot;
  logic [IDW:0]      sum;

  always_comb begin
    shift = '0;
    if (rotate) shift = (last_q == TOP_ID) ? '0 : last_q + IDW'(1);
    dbl  = {cand, cand} >> shift;
    rot  = dbl[NSRC-1:0];
    pick = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (rot[k]) pick = IDW'(k);
    end
    sum    = {1'b0, pick} + {1'b0, shift};
    active = |cand;
    if (!active)           winner = TOP_ID;
    else if (sum >= NSRC_W) winner = IDW'(sum - NSRC_W);
    else                   winner = sum[IDW-1:0];
    last_d = last_q;
    if (active && clr_mask[winner]) last_d = winner;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= TOP_ID;
    else        last_q <= last_d;
  end

endmodule

// File: rtl/vic_rot.sv
module vic_rot
  import vic_rot_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [3:0]      bus_wstrb,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_o,
  output logic            fiq_o
);

  localparam int IDW    = $clog2(NSRC);
  localparam int NCFG_W = NSRC / 4;
  localparam int NSTA_W = NSRC / 32;

  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  logic [5:0]                  widx;
  src_cfg_t [NSRC-1:0]         cfg;
  logic [NDEST-1:0]            rot_mode;
  logic [NSRC-1:0]             clr_mask;
  logic [NSRC-1:0]             pend;
  logic [NDEST-1:0][NSRC-1:0]  cand;
  logic [NDEST-1:0][IDW-1:0]   win;
  logic [NDEST-1:0]            act;

  assign widx = bus_addr[7:2];

  vic_rot_cfg #(.NSRC(NSRC)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_ns),
    .wr_en    (bus_wr),
    .widx     (widx),
    .wstrb    (bus_wstrb),
    .wdata    (bus_wdata),
    .cfg      (cfg),
    .rot_mode (rot_mode),
    .clr_mask (clr_mask)
  );

  vic_rot_pend #(.NSRC(NSRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_ns),
    .src_in   (src_in),
    .cfg      (cfg),
    .clr_mask (clr_mask),
    .pend     (pend)
  );

  generate
    for (genvar d = 0; d < NDEST; d++) begin : g_dest
      for (genvar i = 0; i < NSRC; i++) begin : g_cand
        assign cand[d][i] = pend[i] && cfg[i].en && (cfg[i].dest == 3'(d));
      end
      vic_rot_arb #(.NSRC(NSRC), .IDW(IDW)) u_arb (
        .clk      (clk),
        .rst_n    (rst_ns),
        .cand     (cand[d]),
        .rotate   (rot_mode[d]),
        .clr_mask (clr_mask),
        .winner   (win[d]),
        .active   (act[d])
      );
    end
  endgenerate

  assign irq_o = act[0];
  assign fiq_o = act[1];

  always_comb begin
    bus_rdata = '0;
    if (widx == WIDX_PRIO_IRQ) begin
      bus_rdata[IDW-1:0]  = win[0];
      bus_rdata[ROT_BIT]  = rot_mode[0];
    end
    if (widx == WIDX_PRIO_FIQ) begin
      bus_rdata[IDW-1:0]  = win[1];
      bus_rdata[ROT_BIT]  = rot_mode[1];
    end
    for (int w = 0; w < NCFG_W; w++) begin
      if (widx == WIDX_CFG_BASE + 6'(w)) begin
        for (int l = 0; l < 4; l++) bus_rdata[8*l +: 8] = cfg_to_byte(cfg[4*w + l]);
      end
    end
    for (int w = 0; w < NSTA_W; w++) begin
      if (widx == WIDX_STAT_BASE + 6'(w)) bus_rdata = pend[32*w +: 32];
    end
  end

endmodule

// File: rtl/vic_rot_chk.sv
module vic_rot_chk
  import vic_rot_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int IDW  = 6
) (
  input logic                      clk,
  input logic                      rst_ns,
  input logic [NSRC-1:0]           src_in,
  input logic [NSRC-1:0]           pend,
  input src_cfg_t [NSRC-1:0]       cfg,
  input logic [NSRC-1:0]           clr_mask,
  input logic [NSRC-1:0]           cand_irq,
  input logic [IDW-1:0]            win_irq,
  input logic [IDW-1:0]            win_fiq,
  input logic                      rot_irq,
  input logic                      irq_o,
  input logic                      fiq_o
);

  logic            past_ok;
  logic [NSRC-1:0] lvl_mask, edge_mask, below;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_comb begin
    for (int k = 0; k < NSRC; k++) begin
      lvl_mask[k]  = (cfg[k].trig == TRIG_LEVEL);
      edge_mask[k] = (cfg[k].trig != TRIG_LEVEL);
      below[k]     = (IDW'(k) < win_irq);
    end
  end

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_ns)
    past_ok |-> (((pend ^ $past(src_in)) & $past(lvl_mask)) == '0)); // R3

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    past_ok |-> (($past(pend & edge_mask & ~clr_mask) & ~pend) == '0)); // R4

  AST_IRQ_WINNER_OK: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_o |-> (pend[win_irq] && cfg[win_irq].en && cfg[win_irq].dest == DEST_IRQ)); // R7

  AST_FIQ_WINNER_OK: assert property (@(posedge clk) disable iff (!rst_ns)
    fiq_o |-> (pend[win_fiq] && cfg[win_fiq].en && cfg[win_fiq].dest == DEST_FIQ)); // R7

  AST_IDLE_REPORT: assert property (@(posedge clk) disable iff (!rst_ns)
    !irq_o |-> (win_irq == IDW'(NSRC - 1))); // R8

  AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_ns)
    (!rot_irq && irq_o) |-> ((cand_irq & below) == '0)); // R9

endmodule

bind vic_rot vic_rot_chk #(.NSRC(NSRC), .IDW(IDW)) u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .src_in   (src_in),
  .pend     (pend),
  .cfg      (cfg),
  .clr_mask (clr_mask),
  .cand_irq (cand[0]),
  .win_irq  (win[0]),
  .win_fiq  (win[1]),
  .rot_irq  (rot_mode[0]),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o)
);

// File: tb/vic_rot_test.sv
`timescale 1ns/1ps
module vic_rot_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [3:0]  bus_wstrb;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] src_in;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vic_rot uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wstrb = '0; bus_wdata = '0; src_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wstrb = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wstrb = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_src(input int idx, input logic v);
    @(negedge clk);
    src_in[idx] = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(8'h20, d); chk("R1 irq prio", d, 32'h3F);
    rd(8'h24, d); chk("R1 fiq prio", d, 32'h3F);
    rd(8'h40, d); chk("R1 cfg word 0", d, 32'h0);
    rd(8'h7C, d); chk("R1 cfg word 15", d, 32'h0);
    chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
    chk("R1 fiq_o", {31'd0, fiq_o}, 32'd0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    do_reset();
    wr(8'h44, 4'b0101, 32'hFFFF_FFFF);
    rd(8'h44, d); chk("R2 masked readback", d, 32'h006F_006F);
    wr(8'h48, 4'b0001, 32'hFFFF_FF28);
    rd(8'h48, d); chk("R2 single lane", d, 32'h0000_0028);
  endtask

  task automatic t_level();
    logic [31:0] d;
    do_reset();
    wr(8'h48, 4'b0100, 32'h0008_0000);          // src 10 level, enabled, IRQ
    set_src(10, 1'b1);
    rd(8'h80, d); chk("R3 level pending", d, 32'h0000_0400);
    chk("R3 irq_o high", {31'd0, irq_o}, 32'd1);
    rd(8'h20, d); chk("R3 prio", d, 32'd10);
    wr(8'h80, 4'b1111, 32'h0000_0400);
    rd(8'h80, d); chk("R3 clear ignored while high", d, 32'h0000_0400);
    set_src(10, 1'b0);
    rd(8'h80, d); chk("R3 follows input low", d, 32'h0);
    chk("R3 irq_o low", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    do_reset();
    wr(8'h60, 4'b0010, 32'h0000_2800);          // src 33 rising, enabled, IRQ
    set_src(33, 1'b1);
    set_src(33, 1'b0);
    rd(8'h84, d); chk("R4 latched after drop", d, 32'h0000_0002);
    rd(8'h20, d); chk("R4 prio", d, 32'd33);
    wr(8'h84, 4'b1111, 32'hFFFF_FFFD);
    rd(8'h84, d); chk("R6 zero bit keeps pending", d, 32'h0000_0002);
    wr(8'h84, 4'b1111, 32'h0000_0002);
    rd(8'h84, d); chk("R4 cleared by write", d, 32'h0);
    chk("R4 irq_o low", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    do_reset();
    wr(8'h44, 4'b0011, 32'h0000_6848);          // src 4 falling, src 5 either edge
    set_src(4, 1'b1);
    rd(8'h80, d); chk("R5 no set on rise", d & 32'h10, 32'h0);
    set_src(4, 1'b0);
    rd(8'h80, d); chk("R5 set on fall", d & 32'h10, 32'h10);
    set_src(5, 1'b1);
    rd(8'h80, d); chk("R5 any edge rise", d & 32'h20, 32'h20);
    wr(8'h80, 4'b0001, 32'h0000_0030);
    rd(8'h80, d); chk("R6 low word clear", d, 32'h0);
    set_src(5, 1'b0);
    rd(8'h80, d); chk("R5 any edge fall", d, 32'h20);
  endtask

  task automatic t_route();
    logic [31:0] d;
    do_reset();
    wr(8'h54, 4'b0011, 32'h0000_0A09);          // src 20 FIQ, src 21 dest 2
    set_src(20, 1'b1);
    set_src(21, 1'b1);
    chk("R7 fiq_o high", {31'd0, fiq_o}, 32'd1);
    chk("R7 irq_o low", {31'd0, irq_o}, 32'd0);
    rd(8'h24, d); chk("R7 fiq prio", d, 32'd20);
    rd(8'h20, d); chk("R7 irq idle", d, 32'd63);
    rd(8'h80, d); chk("R6 status both", d, 32'h0030_0000);
    set_src(20, 1'b0);
    chk("R7 aux route silent", {31'd0, fiq_o}, 32'd0);
  endtask

  task automatic t_top_source();
    logic [31:0] d;
    do_reset();
    rd(8'h84, d); chk("R8 idle bit31 clear", d, 32'h0);
    wr(8'h7C, 4'b1000, 32'h0800_0000);          // src 63 level, enabled, IRQ
    set_src(63, 1'b1);
    rd(8'h20, d); chk("R8 real 63 prio", d, 32'd63);
    rd(8'h84, d); chk("R8 real 63 status", d, 32'h8000_0000);
    chk("R8 irq_o", {31'd0, irq_o}, 32'd1);
    wr(8'h24, 4'b0001, 32'h0000_0040);
    rd(8'h24, d); chk("R8 fiq mode bit", d, 32'h0000_007F);
  endtask

  task automatic t_fixed();
    logic [31:0] d;
    do_reset();
    wr(8'h44, 4'b1000, 32'h0800_0000);          // src 7
    wr(8'h4C, 4'b0001, 32'h0000_0008);          // src 12
    wr(8'h68, 4'b0001, 32'h0000_0008);          // src 40
    @(negedge clk);
    src_in[7] = 1'b1; src_in[12] = 1'b1; src_in[40] = 1'b1;
    @(negedge clk);
    rd(8'h20, d); chk("R9 lowest wins", d, 32'd7);
    set_src(7, 1'b0);
    rd(8'h20, d); chk("R9 next lowest", d, 32'd12);
    wr(8'h80, 4'b0010, 32'h0000_1000);
    rd(8'h20, d); chk("R9 fixed after clear", d, 32'd12);
  endtask

  task automatic t_rotate();
    logic [31:0] d;
    do_reset();
    wr(8'h40, 4'b0100, 32'h0008_0000);          // src 2
    wr(8'h44, 4'b0010, 32'h0000_0800);          // src 5
    wr(8'h48, 4'b0010, 32'h0000_0800);          // src 9
    @(negedge clk);
    src_in[2] = 1'b1; src_in[5] = 1'b1; src_in[9] = 1'b1;
    @(negedge clk);
    wr(8'h20, 4'b0001, 32'h0000_0040);
    rd(8'h20, d); chk("R10 start at 0", d, 32'h42);
    wr(8'h80, 4'b0001, 32'h0000_0004);
    rd(8'h20, d); chk("R10 after 2", d, 32'h45);
    wr(8'h80, 4'b0001, 32'h0000_0020);
    rd(8'h20, d); chk("R10 after 5", d, 32'h49);
    wr(8'h80, 4'b0010, 32'h0000_0200);
    rd(8'h20, d); chk("R10 wrap", d, 32'h42);
    wr(8'h80, 4'b0010, 32'h0000_0200);
    rd(8'h20, d); chk("R10 non-winner clear", d, 32'h42);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    do_reset();
    set_src(30, 1'b1);                           // src 30 left at reset config
    rd(8'h80, d); chk("R11 status while disabled", d, 32'h4000_0000);
    chk("R11 irq_o low", {31'd0, irq_o}, 32'd0);
    rd(8'h20, d); chk("R11 not arbitrated", d, 32'd63);
    wr(8'h5C, 4'b0100, 32'h0008_0000);
    chk("R11 enabled raises", {31'd0, irq_o}, 32'd1);
    rd(8'h20, d); chk("R11 prio after enable", d, 32'd30);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_cfg();
    t_level();
    t_rise();
    t_fall();
    t_route();
    t_top_source();
    t_fixed();
    t_rotate();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule